// File: doc/BRIEF.md
# PCI Resource Window Address Translator

This block takes a PCI bus address and the byte address of a device's first resource descriptor, walks that device's chain of descriptors in an attached descriptor memory, and reports whether one of the windows covers the address. On a hit it returns several values taken from the matching descriptor: the CPU physical address, the bus-master address for main memory, the byte-order code, and the access widths it permits. It also returns the I/O and ROM attributes and a flag saying whether the byte order allows direct access. A request is accepted through a valid/ready handshake. The result appears as a one-cycle strobe carrying hit and error flags.

Each descriptor takes five 32-bit words, read through a synchronous port with one cycle of latency:

- Word 0 holds the link length in bits 31:16 and the flag half-word in bits 15:0.
- The following words hold the window start, the window length, the CPU offset and the DMA offset.

The next descriptor sits at the current descriptor's byte address plus the link length. The walk stops early on a hit. It ends as a miss after a descriptor flagged as last. It ends as an error on a broken link, or when the chain runs longer than `MAX_DESC` descriptors.

Top module: `pci_rsc_xlate`

## Requirements
- R1: After reset `req_ready` is 1 and `res_valid` is 0.
- R2: The descriptor at byte pointer P is read from word addresses P/4 to P/4+4. Word 0 is {link[15:0], flags[15:0]}, followed by start, length, cpu offset and dma offset. The next descriptor is at P + link. Link lengths other than 20 are followed too, as long as they are multiples of 4.
- R3: A descriptor covers address A only when start != 0 and start <= A < start + length. The comparison uses 33-bit arithmetic, so a window ending at 2^32 does not wrap.
- R4: On a hit, `res_cpu_addr` = A + cpu offset and `res_dma_addr` = A + dma offset, both modulo 2^32.
- R5: On a hit, the flag fields are returned as follows: `res_width` = flags[10:8] (bit 0 for 8-bit, bit 1 for 16-bit, bit 2 for 32-bit access), `res_io` = flags[14], `res_rom` = flags[13], and `res_order` = flags[3:0].
- R6: `res_direct` is 1 when the byte-order code is 0 (big endian), 1 (little endian address-swapped) or 2 (little endian lane-swapped). It is 0 for codes 3 to 15, which are still returned unchanged in `res_order`.
- R7: If a descriptor with flags[15] (last) set does not cover A, the walk ends with hit=0 and err=0.
- R8: If a non-last descriptor misses and its link is 0, or its link is not a multiple of 4, the walk ends with err=1. A hit on that descriptor still takes priority over the error.
- R9: If `MAX_DESC` (16) descriptors have been examined without a hit and without a last flag, the walk ends with err=1.
- R10: A descriptor with both flags[14] (I/O) and flags[13] (ROM) set is malformed and never produces a hit. The walk continues past it.
- R11: When windows overlap, the first covering descriptor in chain order supplies the result.
- R12: `res_valid` is high for exactly one cycle per accepted request. `req_ready` is low from acceptance until that strobe has been produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Walker idle, request accepted on this cycle if valid |
| req_addr | input | 32 | PCI address to translate |
| req_ptr | input | PTR_W | Byte address of first descriptor (low two bits ignored) |
| mem_rd_en | output | 1 | Descriptor memory read strobe |
| mem_addr | output | PTR_W-2 | Descriptor memory word address |
| mem_rdata | input | 32 | Read data, valid the cycle after the strobe |
| res_valid | output | 1 | One-cycle result strobe |
| res_hit | output | 1 | A window covers the address |
| res_err | output | 1 | Chain broken or too long |
| res_cpu_addr | output | 32 | Translated CPU physical address |
| res_dma_addr | output | 32 | Bus-master main memory address |
| res_order | output | 4 | Byte-order code of the hit window |
| res_direct | output | 1 | Byte order allows direct access |
| res_width | output | 3 | Allowed access widths {32,16,8} |
| res_io | output | 1 | Hit window is I/O space |
| res_rom | output | 1 | Hit window is an expansion ROM |

## Verification
The hardest case to reach from the ports is the walk-length bound. It needs a chain of seventeen well-formed, non-last descriptors, with the requested address placed exactly in the sixteenth window and then in the seventeenth. The bench builds that chain in its memory model with a loop. It then shows that the sixteenth window still hits while the seventeenth produces an error. A window that ends exactly at the top of the 32-bit space is used to expose any wrap in the upper-bound comparison. A malformed I/O-plus-ROM descriptor is placed ahead of a valid window at the same address, which shows that the walk skips the malformed one.

// File: rtl/pci_xlate_pkg.sv
package pci_xlate_pkg;

  localparam int WORD_W   = 32;
  localparam int DESC_WDS = 5;

  typedef struct packed {
    logic [15:0]       link;
    logic [15:0]       flags;
    logic [WORD_W-1:0] start;
    logic [WORD_W-1:0] length;
    logic [WORD_W-1:0] cpu_off;
    logic [WORD_W-1:0] dma_off;
  } rsc_desc_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_EVAL  = 2'd2
  } walk_st_t;

  localparam int FL_LAST = 15;
  localparam int FL_IO   = 14;
  localparam int FL_ROM  = 13;

endpackage

// File: rtl/pci_rsc_match.sv
module pci_rsc_match
  import pci_xlate_pkg::*;
(
  input  rsc_desc_t         desc,
  input  logic [WORD_W-1:0] addr,
  output logic              hit,
  output logic [WORD_W-1:0] cpu_addr,
  output logic [WORD_W-1:0] dma_addr,
  output logic              direct_ok
);

  logic [WORD_W:0] win_end;
  logic            lower_ok;
  logic            upper_ok;
  logic            malformed;

  always_comb begin
    win_end   = {1'b0, desc.start} + {1'b0, desc.length};
    lower_ok  = addr >= desc.start;
    upper_ok  = {1'b0, addr} < win_end;
    malformed = desc.flags[FL_IO] & desc.flags[FL_ROM];
    hit       = (desc.start != '0) & lower_ok & upper_ok & ~malformed;
    cpu_addr  = addr + desc.cpu_off;
    dma_addr  = addr + desc.dma_off;
    direct_ok = desc.flags[3:0] <= 4'd2;
  end

endmodule

// File: rtl/pci_rsc_walk.sv
module pci_rsc_walk
  import pci_xlate_pkg::*;
#(
  parameter int PTR_W    = 10,
  parameter int MAX_DESC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [WORD_W-1:0] req_addr,
  input  logic [PTR_W-1:0]  req_ptr,
  output logic              mem_rd_en,
  output logic [PTR_W-3:0]  mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output rsc_desc_t         desc_q,
  output logic [WORD_W-1:0] addr_q,
  input  logic              m_hit,
  input  logic [WORD_W-1:0] m_cpu,
  input  logic [WORD_W-1:0] m_dma,
  input  logic              m_direct,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_err,
  output logic [WORD_W-1:0] res_cpu_addr,
  output logic [WORD_W-1:0] res_dma_addr,
  output logic [3:0]        res_order,
  output logic              res_direct,
  output logic [2:0]        res_width,
  output logic              res_io,
  output logic              res_rom
);

  localparam int WA_W  = PTR_W - 2;
  localparam int CNT_W = $clog2(MAX_DESC + 1);
  localparam int IDX_W = $clog2(DESC_WDS + 1);

  walk_st_t          state;
  logic [IDX_W-1:0]  idx;
  logic [PTR_W-1:0]  cur_ptr;
  logic [CNT_W-1:0]  cnt;
  logic              bad_link;
  logic              at_cap;

  assign req_ready = (state == ST_IDLE);

  always_comb begin
    mem_rd_en = (state == ST_FETCH) && (idx < IDX_W'(DESC_WDS));
    mem_addr  = cur_ptr[PTR_W-1:2] + WA_W'(idx);
    bad_link  = (desc_q.link == 16'd0) || (desc_q.link[1:0] != 2'b00);
    at_cap    = (cnt == CNT_W'(MAX_DESC - 1));
  end

  always_ff @(posedge clk) begin
    if (state == ST_FETCH && idx != '0) begin
      case (idx)
        IDX_W'(1): {desc_q.link, desc_q.flags} <= mem_rdata;
        IDX_W'(2): desc_q.start   <= mem_rdata;
        IDX_W'(3): desc_q.length  <= mem_rdata;
        IDX_W'(4): desc_q.cpu_off <= mem_rdata;
        default:   desc_q.dma_off <= mem_rdata;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      idx          <= '0;
      cur_ptr      <= '0;
      cnt          <= '0;
      addr_q       <= '0;
      res_valid    <= 1'b0;
      res_hit      <= 1'b0;
      res_err      <= 1'b0;
      res_cpu_addr <= '0;
      res_dma_addr <= '0;
      res_order    <= '0;
      res_direct   <= 1'b0;
      res_width    <= '0;
      res_io       <= 1'b0;
      res_rom      <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            state   <= ST_FETCH;
            idx     <= '0;
            cnt     <= '0;
            cur_ptr <= {req_ptr[PTR_W-1:2], 2'b00};
            addr_q  <= req_addr;
          end
        end
        ST_FETCH: begin
          idx <= idx + 1'b1;
          if (idx == IDX_W'(DESC_WDS)) state <= ST_EVAL;
        end
        default: begin
          if (m_hit || desc_q.flags[FL_LAST] || bad_link || at_cap) begin
            state        <= ST_IDLE;
            res_valid    <= 1'b1;
            res_hit      <= m_hit;
            res_err      <= ~m_hit & ~desc_q.flags[FL_LAST];
            res_cpu_addr <= m_hit ? m_cpu : '0;
            res_dma_addr <= m_hit ? m_dma : '0;
            res_order    <= m_hit ? desc_q.flags[3:0] : 4'd0;
            res_direct   <= m_hit & m_direct;
            res_width    <= m_hit ? desc_q.flags[10:8] : 3'd0;
            res_io       <= m_hit & desc_q.flags[FL_IO];
            res_rom      <= m_hit & desc_q.flags[FL_ROM];
          end else begin
            state   <= ST_FETCH;
            idx     <= '0;
            cnt     <= cnt + 1'b1;
            cur_ptr <= cur_ptr + PTR_W'(desc_q.link);
          end
        end
      endcase
    end
  end

  // R12
  one_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  // R12
  busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> !req_ready);

  // R12
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R9
  walk_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EVAL) |-> (cnt < CNT_W'(MAX_DESC)));

  // R7
  last_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EVAL && desc_q.flags[FL_LAST]) |=> (state == ST_IDLE && res_valid));

  // R3
  hit_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_hit) |-> (desc_q.start != '0 && !res_err));

endmodule

// File: rtl/pci_rsc_xlate.sv
module pci_rsc_xlate
  import pci_xlate_pkg::*;
#(
  parameter int PTR_W    = 10,
  parameter int MAX_DESC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_addr,
  input  logic [PTR_W-1:0]  req_ptr,
  output logic              mem_rd_en,
  output logic [PTR_W-3:0]  mem_addr,
  input  logic [31:0]       mem_rdata,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_err,
  output logic [31:0]       res_cpu_addr,
  output logic [31:0]       res_dma_addr,
  output logic [3:0]        res_order,
  output logic              res_direct,
  output logic [2:0]        res_width,
  output logic              res_io,
  output logic              res_rom
);

  rsc_desc_t         desc_q;
  logic [WORD_W-1:0] addr_q;
  logic              m_hit;
  logic [WORD_W-1:0] m_cpu;
  logic [WORD_W-1:0] m_dma;
  logic              m_direct;

  pci_rsc_match u_match (
    .desc      (desc_q),
    .addr      (addr_q),
    .hit       (m_hit),
    .cpu_addr  (m_cpu),
    .dma_addr  (m_dma),
    .direct_ok (m_direct)
  );

  pci_rsc_walk #(.PTR_W(PTR_W), .MAX_DESC(MAX_DESC)) u_walk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_addr     (req_addr),
    .req_ptr      (req_ptr),
    .mem_rd_en    (mem_rd_en),
    .mem_addr     (mem_addr),
    .mem_rdata    (mem_rdata),
    .desc_q       (desc_q),
    .addr_q       (addr_q),
    .m_hit        (m_hit),
    .m_cpu        (m_cpu),
    .m_dma        (m_dma),
    .m_direct     (m_direct),
    .res_valid    (res_valid),
    .res_hit      (res_hit),
    .res_err      (res_err),
    .res_cpu_addr (res_cpu_addr),
    .res_dma_addr (res_dma_addr),
    .res_order    (res_order),
    .res_direct   (res_direct),
    .res_width    (res_width),
    .res_io       (res_io),
    .res_rom      (res_rom)
  );

endmodule

// File: tb/pci_rsc_xlate_test.sv
module pci_rsc_xlate_test;

  localparam int CLK_PERIOD = 10;
  localparam int PTR_W      = 10;
  localparam int NWORDS     = 1 << (PTR_W - 2);

  localparam logic [15:0] F_LAST = 16'h8000;
  localparam logic [15:0] F_IO   = 16'h4000;
  localparam logic [15:0] F_ROM  = 16'h2000;
  localparam logic [15:0] F_W8   = 16'h0100;
  localparam logic [15:0] F_W16  = 16'h0200;
  localparam logic [15:0] F_W32  = 16'h0400;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [31:0]       req_addr = '0;
  logic [PTR_W-1:0]  req_ptr = '0;
  logic              mem_rd_en;
  logic [PTR_W-3:0]  mem_addr;
  logic [31:0]       mem_rdata;
  logic              res_valid, res_hit, res_err, res_direct, res_io, res_rom;
  logic [31:0]       res_cpu_addr, res_dma_addr;
  logic [3:0]        res_order;
  logic [2:0]        res_width;

  logic [31:0] dmem [NWORDS];

  int total = 0;
  int bad   = 0;

  logic        r_hit, r_err, r_direct, r_io, r_rom;
  logic [31:0] r_cpu, r_dma;
  logic [3:0]  r_order;
  logic [2:0]  r_width;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) if (mem_rd_en) mem_rdata <= dmem[mem_addr];

  pci_rsc_xlate #(.PTR_W(PTR_W), .MAX_DESC(16)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_ptr(req_ptr), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .res_valid(res_valid),
    .res_hit(res_hit), .res_err(res_err), .res_cpu_addr(res_cpu_addr),
    .res_dma_addr(res_dma_addr), .res_order(res_order), .res_direct(res_direct),
    .res_width(res_width), .res_io(res_io), .res_rom(res_rom)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic put_desc(input int ba, input logic [15:0] link, input logic [15:0] flags,
                          input logic [31:0] start, input logic [31:0] len,
                          input logic [31:0] coff, input logic [31:0] doff);
    dmem[(ba >> 2) + 0] = {link, flags};
    dmem[(ba >> 2) + 1] = start;
    dmem[(ba >> 2) + 2] = len;
    dmem[(ba >> 2) + 3] = coff;
    dmem[(ba >> 2) + 4] = doff;
  endtask

  // Drives one request, waits for the strobe and checks the handshake (R12).
  task automatic run_req(input logic [31:0] a, input int p);
    bit got;
    got = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_ptr = PTR_W'(p);
    @(negedge clk);
    req_valid = 1'b0;
    check("R12", "ready low while walking", {31'd0, req_ready}, 32'd0);
    for (int i = 0; i < 400 && !got; i++) begin
      if (res_valid) begin
        got = 1;
        r_hit = res_hit; r_err = res_err; r_cpu = res_cpu_addr; r_dma = res_dma_addr;
        r_order = res_order; r_direct = res_direct; r_width = res_width;
        r_io = res_io; r_rom = res_rom;
      end else @(negedge clk);
    end
    check("R12", "result strobe seen", {31'd0, got}, 32'd1);
    @(negedge clk);
    check("R12", "strobe one cycle", {31'd0, res_valid}, 32'd0);
    check("R12", "ready after result", {31'd0, req_ready}, 32'd1);
  endtask

  task automatic expect_hit(input string req, input logic [31:0] cpu);
    check(req, "hit", {31'd0, r_hit}, 32'd1);
    check(req, "err", {31'd0, r_err}, 32'd0);
    check(req, "cpu addr", r_cpu, cpu);
  endtask

  task automatic expect_miss(input string req, input logic err);
    check(req, "hit", {31'd0, r_hit}, 32'd0);
    check(req, "err", {31'd0, r_err}, {31'd0, err});
  endtask

  task automatic t_reset;
    check("R1", "ready after reset", {31'd0, req_ready}, 32'd1);
    check("R1", "valid after reset", {31'd0, res_valid}, 32'd0);
  endtask

  task automatic t_single_hit;
    put_desc(0, 16'd20, F_LAST | F_W8 | F_W16 | 16'h0002,
             32'h8000_0000, 32'h1000, 32'h4000_0000, 32'h1000_0000);
    run_req(32'h8000_0010, 0);
    expect_hit("R2", 32'hC000_0010);
    check("R4", "dma addr", r_dma, 32'h9000_0010);
    check("R5", "order", {28'd0, r_order}, 32'd2);
    check("R5", "width", {29'd0, r_width}, 32'd3);
    check("R5", "io", {31'd0, r_io}, 32'd0);
    check("R6", "direct for lane swap", {31'd0, r_direct}, 32'd1);
  endtask

  task automatic t_chain;
    put_desc(12'h040, 16'd24, F_W32, 32'h100, 32'h100, 32'd1, 32'd0);
    put_desc(12'h058, 16'd20, F_IO | F_W8 | 16'h0001, 32'h2000, 32'h20, 32'h10, 32'd0);
    put_desc(12'h06C, 16'd20, F_LAST, 32'h2000, 32'h100, 32'h99, 32'd0);
    run_req(32'h2010, 12'h040);
    expect_hit("R11", 32'h2020);
    check("R5", "io", {31'd0, r_io}, 32'd1);
    check("R5", "width 8-bit only", {29'd0, r_width}, 32'd1);
    check("R6", "direct for addr swap", {31'd0, r_direct}, 32'd1);
    run_req(32'h2050, 12'h040);
    expect_hit("R2", 32'h20E9);
    run_req(32'h180, 12'h040);
    expect_hit("R2", 32'h181);
    check("R5", "width 32-bit only", {29'd0, r_width}, 32'd4);
  endtask

  task automatic t_bounds;
    put_desc(12'h0A0, 16'd20, F_LAST, 32'h3000, 32'h10, 32'd0, 32'd0);
    run_req(32'h300F, 12'h0A0);
    expect_hit("R3", 32'h300F);
    run_req(32'h3010, 12'h0A0);
    expect_miss("R7", 1'b0);
    check("R7", "cpu zero on miss", r_cpu, 32'd0);
    run_req(32'h2FFF, 12'h0A0);
    expect_miss("R3", 1'b0);
    put_desc(12'h0C0, 16'd20, F_LAST, 32'hFFFF_F000, 32'h1000, 32'h10, 32'h20);
    run_req(32'hFFFF_FFFF, 12'h0C0);
    expect_hit("R3", 32'h0000_000F);
    check("R4", "dma wrap", r_dma, 32'h0000_001F);
  endtask

  task automatic t_zero_start;
    put_desc(12'h0E0, 16'd20, F_LAST, 32'd0, 32'h1000, 32'd5, 32'd0);
    run_req(32'h10, 12'h0E0);
    expect_miss("R3", 1'b0);
  endtask

  task automatic t_bad_link;
    put_desc(12'h100, 16'd0, 16'h0000, 32'h5000, 32'h10, 32'd0, 32'd0);
    run_req(32'h6000, 12'h100);
    expect_miss("R8", 1'b1);
    run_req(32'h5004, 12'h100);
    expect_hit("R8", 32'h5004);
    put_desc(12'h120, 16'd22, 16'h0000, 32'h5000, 32'h10, 32'd0, 32'd0);
    run_req(32'h6000, 12'h120);
    expect_miss("R8", 1'b1);
  endtask

  task automatic t_order;
    put_desc(12'h140, 16'd20, F_LAST | 16'h0007, 32'h9000, 32'h10, 32'd0, 32'd0);
    run_req(32'h9001, 12'h140);
    expect_hit("R6", 32'h9001);
    check("R6", "reserved order kept", {28'd0, r_order}, 32'd7);
    check("R6", "reserved not direct", {31'd0, r_direct}, 32'd0);
    put_desc(12'h160, 16'd20, F_LAST | 16'h000F, 32'h9000, 32'h10, 32'd0, 32'd0);
    run_req(32'h9001, 12'h160);
    check("R6", "unknown order kept", {28'd0, r_order}, 32'd15);
    check("R6", "unknown not direct", {31'd0, r_direct}, 32'd0);
  endtask

  task automatic t_rom_io;
    put_desc(12'h180, 16'd20, F_ROM | F_IO, 32'hA000, 32'h100, 32'd1, 32'd0);
    put_desc(12'h194, 16'd20, F_LAST | F_ROM, 32'hA000, 32'h100, 32'd2, 32'd0);
    run_req(32'hA000, 12'h180);
    expect_hit("R10", 32'hA002);
    check("R10", "rom", {31'd0, r_rom}, 32'd1);
    check("R10", "io", {31'd0, r_io}, 32'd0);
  endtask

  task automatic t_walk_limit;
    for (int i = 0; i < 17; i++)
      put_desc(12'h200 + i * 20, 16'd20, 16'h0000, 32'h7000_0000 + i * 32'h100,
               32'h100, 32'd3, 32'd0);
    run_req(32'h7000_0F00, 12'h200);
    expect_hit("R9", 32'h7000_0F03);
    run_req(32'h7000_1000, 12'h200);
    expect_miss("R9", 1'b1);
    run_req(32'h1234_0000, 12'h200);
    expect_miss("R9", 1'b1);
  endtask

  initial begin
    for (int i = 0; i < NWORDS; i++) dmem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single_hit();
    t_chain();
    t_bounds();
    t_zero_start();
    t_bad_link();
    t_order();
    t_rom_io();
    t_walk_limit();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule